// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Gate

This block is the register front end of a two-channel IDE expansion card. It sits on a byte-wide memory-mapped bus. It gates the raw interrupt line of each drive channel, reports each channel's pending state, and merges both channels into a single card interrupt. It also holds a select byte that steers the card's one shared DMA path to one channel and opens the extended address window. A small set of strided registers returns a 4-bit board identity code.

The channel gate is controlled by the type of access, not by the data. Any write to a channel's gate address opens that channel's gate. Any read of the same address closes it. Software closes the gate of an empty channel this way, so that its floating interrupt line stays quiet. Read data is registered. It appears in the cycle after the read strobe and is zero in every other cycle.

Top module: `ide_irq_gate`

## Requirements
- R1: A write of any data byte to a gate address (channel 0 at 0x2200, channel 1 at 0x3200) opens that channel's gate from the next cycle.
- R2: A read of a gate address closes that channel's gate from the next cycle and returns 0x00. If a write and a read arrive in the same cycle, the write wins.
- R3: A status read (channel 0 at 0x2290, channel 1 at 0x3290) returns the channel's pending flag in bit 0 and zeros in bits 7:1. The pending flag is the raw drive interrupt, passed through two synchronizing flops, ANDed with the gate. A change on the raw line therefore shows two clock edges later.
- R4: `cardIrq` is high exactly when at least one channel has its pending flag set.
- R5: A write to the select byte at 0x0000 stores the whole byte, and a read of 0x0000 returns it. Bit 0 drives `chanSel` (0 selects channel 0, 1 selects channel 1). Bit 5 drives `regionEn`.
- R6: Writing 0x00 to the select byte drives both `chanSel` and `regionEn` low. This is the shutdown state.
- R7: Identity bit i (i = 0 to 3, least significant first) is read in bit 0 at address 0x2280 + 4*i, with bits 7:1 zero. The default code is 3.
- R8: After reset both gates are closed, the select byte is 0x00, and `cardIrq` and `busRdata` are 0.
- R9: A read of any other address returns 0x00 and changes no gate or select state.
- R10: `busRdata` is valid in the cycle after a read strobe and is 0x00 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 14 | Byte address |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| driveIrq | input | 2 | Raw drive interrupt lines, asynchronous |
| cardIrq | output | 1 | Merged card interrupt |
| chanSel | output | 1 | Channel that owns the shared DMA path |
| regionEn | output | 1 | Extended address window enable |

## Verification
A gate flop stuck in the wrong state shows at the ports in one of two places. It appears on `cardIrq` two edges after the channel's raw line rises, or in bit 0 of the next status read. Each gate is therefore checked both open and closed while its raw line is held high. A wrong synchronizer depth shifts the `cardIrq` edge by one cycle, so that edge is sampled both one and two cycles after the stimulus. Select byte or address decode errors show up in the read of the very next cycle. They also show up on `chanSel`/`regionEn` right after the write, or as a gate left open or closed after a read of an unmapped address.

// File: rtl/ide_gate_pkg.sv
package ide_gate_pkg;
  localparam int NCH = 2;
  localparam int ID_BITS = 4;
  localparam int unsigned SEL_ADDR = 32'h0000;
  localparam int unsigned GATE_ADDR [NCH] = '{32'h2200, 32'h3200};
  localparam int unsigned STAT_ADDR [NCH] = '{32'h2290, 32'h3290};
  localparam int unsigned ID_BASE = 32'h2280;
  localparam int unsigned ID_STRIDE = 4;

  typedef enum logic [1:0] {SRC_NONE, SRC_STAT, SRC_SEL, SRC_ID} rdSrc_e;

  typedef struct packed {
    logic [NCH-1:0] gateSet;
    logic [NCH-1:0] gateClr;
    logic           selWr;
    rdSrc_e         rdSrc;
    logic           statIdx;
    logic [1:0]     idIdx;
  } gateStrobe_t;
endpackage

// File: rtl/ide_gate_ctrl.sv
module ide_gate_ctrl
  import ide_gate_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output gateStrobe_t       strb
);
  always_comb begin
    strb = '0;
    strb.rdSrc = SRC_NONE;
    for (int c = 0; c < NCH; c++) begin
      if (busAddr == ADDR_W'(GATE_ADDR[c])) begin
        strb.gateSet[c] = busWr;
        strb.gateClr[c] = busRd && !busWr;
      end
      if (busRd && busAddr == ADDR_W'(STAT_ADDR[c])) begin
        strb.rdSrc = SRC_STAT;
        strb.statIdx = 1'(c);
      end
    end
    for (int i = 0; i < ID_BITS; i++) begin
      if (busRd && busAddr == ADDR_W'(ID_BASE + ID_STRIDE * i)) begin
        strb.rdSrc = SRC_ID;
        strb.idIdx = 2'(i);
      end
    end
    if (busAddr == ADDR_W'(SEL_ADDR)) begin
      strb.selWr = busWr;
      if (busRd) strb.rdSrc = SRC_SEL;
    end
  end
endmodule

// File: rtl/ide_gate_dp.sv
module ide_gate_dp
  import ide_gate_pkg::*;
#(
  parameter logic [ID_BITS-1:0] BOARD_ID = 4'd3
) (
  input  logic           clk,
  input  logic           rstN,
  input  gateStrobe_t    strb,
  input  logic [7:0]     busWdata,
  input  logic [NCH-1:0] driveIrq,
  output logic [7:0]     busRdata,
  output logic [NCH-1:0] chanEn,
  output logic           cardIrq,
  output logic           chanSel,
  output logic           regionEn
);
  localparam int SEL_CH_BIT = 0;
  localparam int SEL_REGION_BIT = 5;

  logic [NCH-1:0] chanPend;
  logic [7:0]     selByte;

  for (genvar c = 0; c < NCH; c++) begin : gChan
    logic [1:0] syncQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ <= '0;
        chanEn[c] <= 1'b0;
      end else begin
        syncQ <= {syncQ[0], driveIrq[c]};
        if (strb.gateSet[c]) chanEn[c] <= 1'b1;
        else if (strb.gateClr[c]) chanEn[c] <= 1'b0;
      end
    end
    assign chanPend[c] = syncQ[1] & chanEn[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) selByte <= '0;
    else if (strb.selWr) selByte <= busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else begin
      unique case (strb.rdSrc)
        SRC_STAT: busRdata <= {7'b0, chanPend[strb.statIdx]};
        SRC_SEL:  busRdata <= selByte;
        SRC_ID:   busRdata <= {7'b0, BOARD_ID[strb.idIdx]};
        default:  busRdata <= 8'h00;
      endcase
    end
  end

  assign cardIrq  = |chanPend;
  assign chanSel  = selByte[SEL_CH_BIT];
  assign regionEn = selByte[SEL_REGION_BIT];
endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
  import ide_gate_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter logic [ID_BITS-1:0] BOARD_ID = 4'd3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [NCH-1:0]    driveIrq,
  output logic              cardIrq,
  output logic              chanSel,
  output logic              regionEn
);
  gateStrobe_t    strb;
  logic [NCH-1:0] chanEn;

  ide_gate_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .strb(strb)
  );

  ide_gate_dp #(.BOARD_ID(BOARD_ID)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .driveIrq(driveIrq), .busRdata(busRdata), .chanEn(chanEn),
    .cardIrq(cardIrq), .chanSel(chanSel), .regionEn(regionEn)
  );
endmodule

// File: rtl/ide_irq_gate_chk.sv
module ide_irq_gate_chk
  import ide_gate_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic [NCH-1:0]    chanEn,
  input logic              cardIrq,
  input logic              chanSel,
  input logic              regionEn
);
  assert_gate0_open_R1: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'(GATE_ADDR[0]) |=> chanEn[0]);
  assert_gate1_open_R1: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'(GATE_ADDR[1]) |=> chanEn[1]);
  assert_gate0_close_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busWr && busAddr == ADDR_W'(GATE_ADDR[0]) |=> !chanEn[0] && busRdata == 8'h00);
  assert_gate1_close_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busWr && busAddr == ADDR_W'(GATE_ADDR[1]) |=> !chanEn[1] && busRdata == 8'h00);
  assert_stat_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    busRd && (busAddr == ADDR_W'(STAT_ADDR[0]) || busAddr == ADDR_W'(STAT_ADDR[1]))
    |=> busRdata[7:1] == 7'b0);
  assert_irq_needs_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    cardIrq |-> (|chanEn));
  assert_sel_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'(SEL_ADDR) && busWdata == 8'h00 |=> !chanSel && !regionEn);
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> busRdata == 8'h00);
endmodule

bind ide_irq_gate ide_irq_gate_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busWdata(busWdata), .busRdata(busRdata), .chanEn(chanEn),
  .cardIrq(cardIrq), .chanSel(chanSel), .regionEn(regionEn)
);

// File: tb/ide_irq_gate_test.sv
`timescale 1ns/1ps
module ide_irq_gate_test;
  logic clk = 0;
  logic rstN = 0;
  logic [13:0] busAddr = '0;
  logic busRd = 0, busWr = 0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [1:0] driveIrq = '0;
  logic cardIrq, chanSel, regionEn;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expQ [$];
  string tagQ [$];

  always #5 clk = ~clk;

  ide_irq_gate uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .driveIrq(driveIrq),
    .cardIrq(cardIrq), .chanSel(chanSel), .regionEn(regionEn)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic busRead(input logic [13:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    busAddr = a; busRd = 1;
    @(negedge clk);
    busRd = 0;
  endtask

  // monitor: compare each read result one cycle after its strobe
  initial begin
    forever begin
      @(posedge clk);
      if (busRd && expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        @(negedge clk);
        check(t, busRdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 cardIrq", {7'b0, cardIrq}, 8'h00);
    check("R8 chanSel", {7'b0, chanSel}, 8'h00);
    check("R8 regionEn", {7'b0, regionEn}, 8'h00);
    check("R8 busRdata", busRdata, 8'h00);
    rstN = 1;
    // R3 gate closed: raw line high gives nothing
    driveIrq = 2'b01;
    repeat (3) @(negedge clk);
    check("R3 closed gate cardIrq", {7'b0, cardIrq}, 8'h00);
    busRead(14'h2290, 8'h00, "R8 R3 stat0 closed");
    // R1 open ch0 with arbitrary data
    busWrite(14'h2200, 8'hA5);
    check("R1 R4 cardIrq after open", {7'b0, cardIrq}, 8'h01);
    busRead(14'h2290, 8'h01, "R1 R3 stat0 pending");
    busRead(14'h3290, 8'h00, "R3 stat1 idle");
    // R2 close via read
    busRead(14'h2200, 8'h00, "R2 gate read data");
    check("R2 cardIrq after close", {7'b0, cardIrq}, 8'h00);
    busRead(14'h2290, 8'h00, "R2 stat0 closed");
    // R3 latency on ch1
    busWrite(14'h3200, 8'h00);
    @(negedge clk); driveIrq[1] = 1;
    @(negedge clk);
    check("R3 one edge later", {7'b0, cardIrq}, 8'h00);
    @(negedge clk);
    check("R3 R4 two edges later", {7'b0, cardIrq}, 8'h01);
    busRead(14'h3290, 8'h01, "R3 stat1 pending");
    driveIrq[1] = 0;
    @(negedge clk);
    check("R3 fall one edge", {7'b0, cardIrq}, 8'h01);
    @(negedge clk);
    check("R4 fall two edges", {7'b0, cardIrq}, 8'h00);
    // R7 identity
    busRead(14'h2280, 8'h01, "R7 id bit0");
    busRead(14'h2284, 8'h01, "R7 id bit1");
    busRead(14'h2288, 8'h00, "R7 id bit2");
    busRead(14'h228C, 8'h00, "R7 id bit3");
    // R5 select byte
    busWrite(14'h0000, 8'h21);
    check("R5 chanSel", {7'b0, chanSel}, 8'h01);
    check("R5 regionEn", {7'b0, regionEn}, 8'h01);
    busRead(14'h0000, 8'h21, "R5 sel readback");
    busWrite(14'h0000, 8'h01);
    check("R5 region off", {6'b0, regionEn, chanSel}, 8'h01);
    busWrite(14'h0000, 8'h20);
    check("R5 ch0 region on", {6'b0, regionEn, chanSel}, 8'h02);
    busWrite(14'h0000, 8'h00);
    check("R6 shutdown", {6'b0, regionEn, chanSel}, 8'h00);
    busRead(14'h0000, 8'h00, "R6 sel readback");
    // R9 unmapped reads, ch1 gate still open
    busRead(14'h2204, 8'h00, "R9 unmapped 2204");
    busRead(14'h2281, 8'h00, "R9 unmapped 2281");
    busRead(14'h1234, 8'h00, "R9 unmapped 1234");
    driveIrq[1] = 1;
    repeat (2) @(negedge clk);
    check("R9 ch1 gate kept", {7'b0, cardIrq}, 8'h01);
    check("R9 sel kept", {6'b0, regionEn, chanSel}, 8'h00);
    // R4 both channels, close ch1 only
    busWrite(14'h2200, 8'hFF);
    busRead(14'h3200, 8'h00, "R2 close ch1");
    check("R4 ch0 still drives", {7'b0, cardIrq}, 8'h01);
    busRead(14'h3290, 8'h00, "R2 stat1 closed");
    busRead(14'h2290, 8'h01, "R4 stat0 pending");
    // R2 write wins over read in same cycle
    @(negedge clk);
    busAddr = 14'h3200; busWr = 1; busRd = 1;
    expQ.push_back(8'h00); tagQ.push_back("R2 same cycle data");
    @(negedge clk);
    busWr = 0; busRd = 0;
    busRead(14'h3290, 8'h01, "R2 write wins");
    // R10 idle rdata
    @(negedge clk);
    check("R10 idle rdata", busRdata, 8'h00);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule